// File: doc/BRIEF.md
# Hardwired Step-Counter Control Unit

This block drives the enable lines of a single-bus processor datapath from a control-step counter, without any control store. The counter value goes to a step decoder that raises exactly one of the timing lines T1..Tn. The instruction opcode goes to an instruction decoder that raises one instruction line. An encoder then forms each enable as an OR of step-and-instruction product terms.

The block covers a three-step fetch and three instructions. The first is a memory-indirect add that reads the operand addressed by R3 and adds it into R1. The second is an unconditional branch. The third is a branch taken only when the N condition flag is set. In both branches the target is the incremented PC plus the offset field of the instruction. The counter waits on memory completion during wait steps and returns to T1 on the clock after End. It counts only while the run input is high.

Top module: `hw_ctrl_unit`

## Requirements
- R1: While rst_ni is low, and on the first cycle after its release, the counter is at T1 (step_o == 1, where step_o bit k stands for T(k+1)).
- R2: At T1, for any opcode, exactly pc_out, mar_in, rd, sel4, add and z_in are high.
- R3: At T2 exactly z_out, pc_in, y_in and wmfc are high. At T3 exactly mdr_out and ir_in are high.
- R4: With opcode 4'h1 (add through R3 into R1), step T4 gives r3_out, mar_in and rd. T5 gives r1_out, y_in and wmfc. T6 gives mdr_out, sel_y, add and z_in. T7 gives z_out, r1_in and end.
- R5: With opcode 4'h2 (branch), step T4 gives off_out, add and z_in. T5 gives z_out, pc_in and end.
- R6: With opcode 4'h3 (branch if negative) and n_i = 1, the signals match R5. With n_i = 0, only end is high at T4.
- R7: With any other opcode, only end is high at T4.
- R8: While wmfc is high and mfc_i is low, the step holds. After a clock edge with mfc_i high, the next step follows.
- R9: After a clock edge with run_i and end both high, the counter is at T1.
- R10: While run_i is low, the step holds, and the outputs keep showing the current step.
- R11: At most one of pc_out, mdr_out, z_out, r1_out, r3_out and off_out is high at a time, and z_in and z_out are never high together.
- R12: step_o is always one-hot, and while run_i is high with no stall and no end, it moves up by one position per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter advance enable |
| opc_i | input | OPC_W | Opcode field of the instruction register |
| n_i | input | 1 | Negative condition flag |
| mfc_i | input | 1 | Memory function completed |
| step_o | output | N_STEPS | One-hot timing lines, bit 0 = T1 |
| pc_out_o | output | 1 | PC drives bus |
| pc_in_o | output | 1 | PC loads from bus |
| mar_in_o | output | 1 | MAR loads from bus |
| mdr_out_o | output | 1 | MDR drives bus |
| ir_in_o | output | 1 | IR loads from bus |
| y_in_o | output | 1 | Y loads from bus |
| z_in_o | output | 1 | Z loads ALU result |
| z_out_o | output | 1 | Z drives bus |
| r1_out_o | output | 1 | R1 drives bus |
| r1_in_o | output | 1 | R1 loads from bus |
| r3_out_o | output | 1 | R3 drives bus |
| off_out_o | output | 1 | IR offset field drives bus |
| rd_o | output | 1 | Memory read request |
| sel4_o | output | 1 | ALU A input takes constant 4 |
| sel_y_o | output | 1 | ALU A input takes Y |
| add_o | output | 1 | ALU adds |
| wmfc_o | output | 1 | Wait for memory completion |
| end_o | output | 1 | Last step of the instruction |

## Verification
The enables are combinational from the step register and the opcode, N and MFC inputs. They are therefore due in the same cycle the inputs are applied, and the bench checks them 1 ns after it drives inputs at the falling edge. The step changes one clock edge later, so the bench updates its own step model after each check and compares step_o in the following cycle. Memory latencies of zero to two cycles and run gaps are swept over all 16 opcodes and both N values. This exercises the holds and the restarts against that one-edge model.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int INS_ADD = 0;
  localparam int INS_BR  = 1;
  localparam int INS_BRN = 2;
  localparam int INS_OTH = 3;
  localparam int N_INS   = 4;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mdr_out;
    logic ir_in;
    logic y_in;
    logic z_in;
    logic z_out;
    logic r1_out;
    logic r1_in;
    logic r3_out;
    logic off_out;
    logic rd;
    logic sel4;
    logic sel_y;
    logic add;
    logic wmfc;
    logic fin;
  } ctrl_t;
endpackage

// File: rtl/step_counter.sv
module step_counter #(
  parameter int N_STEPS = 8,
  localparam int CW = $clog2(N_STEPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          stall_i,
  input  logic          fin_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (run_i) begin
      if (fin_i)          cnt_o <= '0;
      else if (!stall_i)  cnt_o <= cnt_o + 1'b1;
    end
  end

  a_r10_run_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_o));
endmodule

// File: rtl/step_decoder.sv
module step_decoder #(
  parameter int N_STEPS = 8,
  localparam int CW = $clog2(N_STEPS)
) (
  input  logic [CW-1:0]      cnt_i,
  output logic [N_STEPS-1:0] t_o
);
  for (genvar k = 0; k < N_STEPS; k++) begin : g_t
    assign t_o[k] = (cnt_i == CW'(k));
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import ctrl_pkg::*;
#(
  parameter int               OPC_W   = 4,
  parameter logic [OPC_W-1:0] OPC_ADD = 'h1,
  parameter logic [OPC_W-1:0] OPC_BR  = 'h2,
  parameter logic [OPC_W-1:0] OPC_BRN = 'h3
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic [N_INS-1:0] ins_o
);
  always_comb begin
    ins_o          = '0;
    ins_o[INS_ADD] = (opc_i == OPC_ADD);
    ins_o[INS_BR]  = (opc_i == OPC_BR);
    ins_o[INS_BRN] = (opc_i == OPC_BRN);
    ins_o[INS_OTH] = ~|ins_o[INS_BRN:INS_ADD];
  end
endmodule

// File: rtl/signal_encoder.sv
module signal_encoder
  import ctrl_pkg::*;
#(
  parameter int N_STEPS = 8
) (
  input  logic [N_STEPS-1:0] t_i,
  input  logic [N_INS-1:0]   ins_i,
  input  logic               n_i,
  output ctrl_t              c_o
);
  logic i_add, take, skip;
  logic t1, t2, t3, t4, t5, t6, t7;

  always_comb begin
    {t7, t6, t5, t4, t3, t2, t1} = t_i[6:0];
    i_add = ins_i[INS_ADD];
    take  = ins_i[INS_BR] | (ins_i[INS_BRN] & n_i);
    skip  = (ins_i[INS_BRN] & ~n_i) | ins_i[INS_OTH];

    c_o.pc_out  = t1;
    c_o.sel4    = t1;
    c_o.ir_in   = t3;
    c_o.mar_in  = t1 | (t4 & i_add);
    c_o.rd      = t1 | (t4 & i_add);
    c_o.add     = t1 | (t6 & i_add) | (t4 & take);
    c_o.z_in    = t1 | (t6 & i_add) | (t4 & take);
    c_o.z_out   = t2 | (t7 & i_add) | (t5 & take);
    c_o.pc_in   = t2 | (t5 & take);
    c_o.y_in    = t2 | (t5 & i_add);
    c_o.wmfc    = t2 | (t5 & i_add);
    c_o.mdr_out = t3 | (t6 & i_add);
    c_o.r3_out  = t4 & i_add;
    c_o.r1_out  = t5 & i_add;
    c_o.sel_y   = t6 & i_add;
    c_o.r1_in   = t7 & i_add;
    c_o.off_out = t4 & take;
    c_o.fin     = (t7 & i_add) | (t5 & take) | (t4 & skip);
  end
endmodule

// File: rtl/hw_ctrl_unit.sv
module hw_ctrl_unit
  import ctrl_pkg::*;
#(
  parameter int               OPC_W   = 4,
  parameter int               N_STEPS = 8,
  parameter logic [OPC_W-1:0] OPC_ADD = 'h1,
  parameter logic [OPC_W-1:0] OPC_BR  = 'h2,
  parameter logic [OPC_W-1:0] OPC_BRN = 'h3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [OPC_W-1:0]   opc_i,
  input  logic               n_i,
  input  logic               mfc_i,
  output logic [N_STEPS-1:0] step_o,
  output logic               pc_out_o,
  output logic               pc_in_o,
  output logic               mar_in_o,
  output logic               mdr_out_o,
  output logic               ir_in_o,
  output logic               y_in_o,
  output logic               z_in_o,
  output logic               z_out_o,
  output logic               r1_out_o,
  output logic               r1_in_o,
  output logic               r3_out_o,
  output logic               off_out_o,
  output logic               rd_o,
  output logic               sel4_o,
  output logic               sel_y_o,
  output logic               add_o,
  output logic               wmfc_o,
  output logic               end_o
);
  localparam int CW = $clog2(N_STEPS);

  logic [CW-1:0]    cnt;
  logic [N_INS-1:0] ins;
  ctrl_t            c;
  logic             stall;

  assign stall = c.wmfc & ~mfc_i;

  step_counter #(.N_STEPS(N_STEPS)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .stall_i(stall), .fin_i(c.fin), .cnt_o(cnt)
  );

  step_decoder #(.N_STEPS(N_STEPS)) u_sdec (.cnt_i(cnt), .t_o(step_o));

  instr_decoder #(
    .OPC_W(OPC_W), .OPC_ADD(OPC_ADD), .OPC_BR(OPC_BR), .OPC_BRN(OPC_BRN)
  ) u_idec (.opc_i(opc_i), .ins_o(ins));

  signal_encoder #(.N_STEPS(N_STEPS)) u_enc (
    .t_i(step_o), .ins_i(ins), .n_i(n_i), .c_o(c)
  );

  assign pc_out_o  = c.pc_out;
  assign pc_in_o   = c.pc_in;
  assign mar_in_o  = c.mar_in;
  assign mdr_out_o = c.mdr_out;
  assign ir_in_o   = c.ir_in;
  assign y_in_o    = c.y_in;
  assign z_in_o    = c.z_in;
  assign z_out_o   = c.z_out;
  assign r1_out_o  = c.r1_out;
  assign r1_in_o   = c.r1_in;
  assign r3_out_o  = c.r3_out;
  assign off_out_o = c.off_out;
  assign rd_o      = c.rd;
  assign sel4_o    = c.sel4;
  assign sel_y_o   = c.sel_y;
  assign add_o     = c.add;
  assign wmfc_o    = c.wmfc;
  assign end_o     = c.fin;

  a_r8_wmfc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wmfc_o && !mfc_i) |=> $stable(step_o));
  a_r9_end_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && end_o) |=> step_o[0]);
  a_r11_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pc_out_o, mdr_out_o, z_out_o, r1_out_o, r3_out_o, off_out_o}) <= 1
    && !(z_in_o && z_out_o));
  a_r12_step_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_o) == 1);
  a_r12_step_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !end_o && !(wmfc_o && !mfc_i)) |=> (step_o == ($past(step_o) << 1)));
endmodule

// File: tb/hw_ctrl_unit_test.sv
module hw_ctrl_unit_test;
  localparam int N_STEPS = 8;
  // bit positions of the packed enable vector
  localparam int B_PCO = 17, B_PCI = 16, B_MAR = 15, B_MDO = 14, B_IRI = 13,
                 B_YI = 12, B_ZI = 11, B_ZO = 10, B_R1O = 9, B_R1I = 8,
                 B_R3O = 7, B_OFF = 6, B_RD = 5, B_S4 = 4, B_SY = 3,
                 B_ADD = 2, B_WM = 1, B_END = 0;

  logic clk = 0, rst_ni = 0, run_i = 0, n_i = 0, mfc_i = 0;
  logic [3:0] opc_i = 0;
  logic [N_STEPS-1:0] step_o;
  logic pc_out_o, pc_in_o, mar_in_o, mdr_out_o, ir_in_o, y_in_o, z_in_o, z_out_o;
  logic r1_out_o, r1_in_o, r3_out_o, off_out_o, rd_o, sel4_o, sel_y_o, add_o;
  logic wmfc_o, end_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hw_ctrl_unit uut (.*, .clk_i(clk));

  function automatic logic [17:0] outs();
    return {pc_out_o, pc_in_o, mar_in_o, mdr_out_o, ir_in_o, y_in_o, z_in_o,
            z_out_o, r1_out_o, r1_in_o, r3_out_o, off_out_o, rd_o, sel4_o,
            sel_y_o, add_o, wmfc_o, end_o};
  endfunction

  function automatic logic [17:0] bits(input int a[$]);
    logic [17:0] v = '0;
    foreach (a[i]) v[a[i]] = 1'b1;
    return v;
  endfunction

  // expected enables from the requirement text, step s = 1..7
  function automatic logic [17:0] expect_c(input int s, input int op, input logic n);
    bit take = (op == 2) || (op == 3 && n);
    case (s)
      1: return bits('{B_PCO, B_MAR, B_RD, B_S4, B_ADD, B_ZI});
      2: return bits('{B_ZO, B_PCI, B_YI, B_WM});
      3: return bits('{B_MDO, B_IRI});
      default: ;
    endcase
    if (op == 1) begin
      case (s)
        4: return bits('{B_R3O, B_MAR, B_RD});
        5: return bits('{B_R1O, B_YI, B_WM});
        6: return bits('{B_MDO, B_SY, B_ADD, B_ZI});
        7: return bits('{B_ZO, B_R1I, B_END});
        default: return '0;
      endcase
    end
    if (take) begin
      case (s)
        4: return bits('{B_OFF, B_ADD, B_ZI});
        5: return bits('{B_ZO, B_PCI, B_END});
        default: return '0;
      endcase
    end
    return (s == 4) ? bits('{B_END}) : '0;
  endfunction

  function automatic string tag_of(input int s, input int op);
    if (s == 1) return "R2";
    if (s <= 3) return "R3";
    if (op == 1) return "R4";
    if (op == 2) return "R5";
    if (op == 3) return "R6";
    return "R7";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one instruction from T1 back to T1; d = memory latency, gap = run holes
  task automatic run_instr(input int op, input logic n, input int d, input bit gap);
    int s = 1, wait_c = 0, cyc = 0;
    bit done = 0;
    while (!done) begin
      logic [17:0] e;
      @(negedge clk);
      opc_i = op[3:0];
      n_i   = n;
      run_i = !(gap && (cyc % 3 == 1));
      e     = expect_c(s, op, n);
      mfc_i = e[B_WM] && (wait_c >= d);
      #1;
      chk(step_o == N_STEPS'(1) << (s - 1), "R12/R8/R9/R10 step", 32'(step_o), 32'(1) << (s - 1));
      chk(outs() == e, tag_of(s, op), 32'(outs()), 32'(e));
      chk($countones({pc_out_o, mdr_out_o, z_out_o, r1_out_o, r3_out_o, off_out_o}) <= 1
          && !(z_in_o && z_out_o), "R11 bus", 32'(outs()), 32'(e));
      if (run_i) begin
        if (e[B_END]) begin s = 1; done = 1; end
        else if (e[B_WM] && !mfc_i) wait_c++;
        else begin s++; wait_c = 0; end
      end
      cyc++;
      if (cyc > 100) done = 1;
    end
  endtask

  initial begin
    #2;
    chk(step_o == 1, "R1 reset step", 32'(step_o), 1);
    chk(outs() == expect_c(1, 0, 0), "R1 reset outputs", 32'(outs()), 32'(expect_c(1, 0, 0)));
    repeat (2) @(negedge clk);
    rst_ni = 1;
    #1;
    chk(step_o == 1, "R1 after release", 32'(step_o), 1);
    for (int op = 0; op < 16; op++)
      for (int n = 0; n < 2; n++)
        for (int d = 0; d < 3; d++)
          for (int g = 0; g < 2; g++)
            run_instr(op, n[0], d, g[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule